// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block turns pairs of parallel 20-bit stereo samples into a single serial data bit stream. Once per sample period it sends the left word and then the right word, most significant bit first, in two's complement exactly as supplied. The bit clock, the word-select (channel) clock and a frame-sync enable arrive from outside. They are oversampled in the system clock domain, and the serial bit is updated from a register one system clock after a falling bit-clock edge is seen. In the master framings those clocks come from a separate clock generator, so this block only follows them.

Two static format pins pick one of four framings. The framings differ in three ways: which word-select level means "left", whether the MSB appears on the slot of the word-select edge or one slot later, and whether the frame-sync input gates the bit advance. A sample pair written with a valid strobe is held in a pending register. It is committed at the start of the next left half-frame, so a strobe in the middle of a frame takes effect at the following frame.

Top module: `audtx_serializer`

## Requirements
- R1: After reset, and until the first word-select change seen after reset, `ser_out` is 0.
- R2: Format code {fmt_i2s, fmt_mst} = 00 (slave MSB-justified): word_sel high marks the left channel. The MSB is driven in the bit slot that starts at the falling bit-clock edge where word_sel changes.
- R3: Format codes 10 (slave I2S) and 11 (master I2S): word_sel low marks the left channel. The slot of the word-select edge carries 0, and the MSB follows in the next slot.
- R4: Format code 01 (master I2S-like): word_sel high marks the left channel, and the MSB comes one slot after the word-select edge.
- R5: Each channel word is 20 bits, sent MSB first with its bits unchanged. Left goes in the half-frame with the left word-select level, right in the other half.
- R6: Once all 20 bits of a channel have been sent, `ser_out` is 0 for the rest of that half-frame. With a 64-slot frame, that is 12 slots minus the delay slot.
- R7: In format 00, each bit after the MSB advances only on a falling bit-clock edge where frame_en is high. On any other falling edge, `ser_out` holds its value.
- R8: In formats 01, 10 and 11, frame_en has no effect on `ser_out`.
- R9: A pair strobed by word_valid is committed at the next left-channel start. Right data comes from the pair committed at that same start. With no new strobe, the last committed pair repeats every frame.
- R10: `ser_out` changes only in the system clock cycle that follows a detected falling bit-clock edge. It stays stable for the rest of the bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| fmt_mst | input | 1 | Format pin: master variant when high |
| fmt_i2s | input | 1 | Format pin: I2S word-select polarity when high |
| left_word | input | 20 | Left sample, two's complement |
| right_word | input | 20 | Right sample, two's complement |
| word_valid | input | 1 | One-cycle strobe that captures left_word and right_word |
| bit_clk | input | 1 | Serial bit clock |
| word_sel | input | 1 | Word-select (channel) clock |
| frame_en | input | 1 | Frame-sync enable for bit advance |
| ser_out | output | 1 | Registered serial data bit |

## Verification
The bench builds the block with its default parameters: 20-bit words and a two-stage input synchronizer. It drives a 64-slot frame in which each bit slot lasts eight system clocks. This leaves 12 padding slots per channel, so the zero-fill after the LSB and the one-slot delay of the I2S framings can both be seen in every frame. Frame-sync patterns with gaps are applied in each format. In the MSB-justified format they show bits being held. In the other formats the same kind of patterns must leave the output unchanged. Strobes placed inside the left half and inside the right half show when a new pair takes effect.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  typedef enum logic [1:0] {
    FMT_SLV_MSBJ = 2'b00,
    FMT_MST_LIKE = 2'b01,
    FMT_SLV_I2S  = 2'b10,
    FMT_MST_I2S  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic left_hi;   // word-select high means left channel
    logic late_msb;  // MSB one slot after the word-select edge
    logic fr_gate;   // frame_en gates the bit advance
  } fmt_cfg_t;

  function automatic fmt_cfg_t decode_fmt(input logic i2s_sel, input logic mst_sel);
    fmt_cfg_t c;
    fmt_e     f;
    f = fmt_e'({i2s_sel, mst_sel});
    case (f)
      FMT_SLV_MSBJ: c = '{left_hi: 1'b1, late_msb: 1'b0, fr_gate: 1'b1};
      FMT_MST_LIKE: c = '{left_hi: 1'b1, late_msb: 1'b1, fr_gate: 1'b0};
      FMT_SLV_I2S:  c = '{left_hi: 1'b0, late_msb: 1'b1, fr_gate: 1'b0};
      default:      c = '{left_hi: 1'b0, late_msb: 1'b1, fr_gate: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/audtx_insync.sv
module audtx_insync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/audtx_slot_ctl.sv
module audtx_slot_ctl
  import audtx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic i2s_sel,
  input  logic mst_sel,
  input  logic bclk_s,
  input  logic ws_s,
  input  logic fr_s,
  output logic fall,
  output logic ws_chg,
  output logic left_now,
  output logic left_start,
  output logic late_msb,
  output logic fr_gate,
  output logic adv_ok
);
  fmt_cfg_t cfg_q;
  logic     bclk_d;
  logic     ws_prev;
  logic     armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      bclk_d  <= 1'b0;
      ws_prev <= 1'b0;
      armed   <= 1'b0;
    end else begin
      cfg_q  <= decode_fmt(i2s_sel, mst_sel);
      bclk_d <= bclk_s;
      if (fall) begin
        ws_prev <= ws_s;
        armed   <= 1'b1;
      end
    end
  end

  assign fall       = bclk_d & ~bclk_s;
  assign ws_chg     = fall & armed & (ws_s != ws_prev);
  assign left_now   = (ws_s == cfg_q.left_hi);
  assign left_start = ws_chg & left_now;
  assign late_msb   = cfg_q.late_msb;
  assign fr_gate    = cfg_q.fr_gate;
  assign adv_ok     = ~cfg_q.fr_gate | fr_s;
endmodule

// File: rtl/audtx_hold.sv
module audtx_hold #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_valid,
  input  logic [DW-1:0] left_word,
  input  logic [DW-1:0] right_word,
  input  logic          left_start,
  input  logic          left_now,
  output logic [DW-1:0] ld_word
);
  logic [DW-1:0] pend_l;
  logic [DW-1:0] pend_r;
  logic [DW-1:0] frame_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l  <= '0;
      pend_r  <= '0;
      frame_r <= '0;
    end else begin
      if (word_valid) begin
        pend_l <= left_word;
        pend_r <= right_word;
      end
      if (left_start) frame_r <= pend_r;
    end
  end

  assign ld_word = left_now ? pend_l : frame_r;
endmodule

// File: rtl/audtx_shift.sv
module audtx_shift #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          ws_chg,
  input  logic          late_msb,
  input  logic          adv_ok,
  input  logic [DW-1:0] ld_word,
  output logic          sdata
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh;
  logic [CW-1:0] remain;
  logic          msb_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      remain   <= '0;
      msb_wait <= 1'b0;
      sdata    <= 1'b0;
    end else if (ws_chg) begin
      if (late_msb) begin
        sh       <= ld_word;
        remain   <= CW'(DW);
        msb_wait <= 1'b1;
        sdata    <= 1'b0;
      end else begin
        sh       <= {ld_word[DW-2:0], 1'b0};
        remain   <= CW'(DW - 1);
        msb_wait <= 1'b0;
        sdata    <= ld_word[DW-1];
      end
    end else if (fall) begin
      if (msb_wait) begin
        sdata    <= sh[DW-1];
        sh       <= {sh[DW-2:0], 1'b0};
        remain   <= remain - 1'b1;
        msb_wait <= 1'b0;
      end else if (adv_ok) begin
        if (remain != '0) begin
          sdata  <= sh[DW-1];
          sh     <= {sh[DW-2:0], 1'b0};
          remain <= remain - 1'b1;
        end else begin
          sdata  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
  import audtx_pkg::*;
#(
  parameter int DW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmt_mst,
  input  logic          fmt_i2s,
  input  logic [DW-1:0] left_word,
  input  logic [DW-1:0] right_word,
  input  logic          word_valid,
  input  logic          bit_clk,
  input  logic          word_sel,
  input  logic          frame_en,
  output logic          ser_out
);
  logic [2:0]    sync_v;
  logic          fall, ws_chg, left_now, left_start, late_msb, fr_gate, adv_ok;
  logic [DW-1:0] ld_word;

  audtx_insync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({frame_en, word_sel, bit_clk}),
    .q   (sync_v)
  );

  audtx_slot_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .i2s_sel    (fmt_i2s),
    .mst_sel    (fmt_mst),
    .bclk_s     (sync_v[0]),
    .ws_s       (sync_v[1]),
    .fr_s       (sync_v[2]),
    .fall       (fall),
    .ws_chg     (ws_chg),
    .left_now   (left_now),
    .left_start (left_start),
    .late_msb   (late_msb),
    .fr_gate    (fr_gate),
    .adv_ok     (adv_ok)
  );

  audtx_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .left_word  (left_word),
    .right_word (right_word),
    .left_start (left_start),
    .left_now   (left_now),
    .ld_word    (ld_word)
  );

  audtx_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .fall     (fall),
    .ws_chg   (ws_chg),
    .late_msb (late_msb),
    .adv_ok   (adv_ok),
    .ld_word  (ld_word),
    .sdata    (ser_out)
  );
endmodule

// File: rtl/audtx_serializer_chk.sv
module audtx_serializer_chk (
  input logic clk,
  input logic rst,
  input logic fall,
  input logic ws_chg,
  input logic late_msb,
  input logic fr_gate,
  input logic fr_s,
  input logic ld_msb,
  input logic ser_out
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ser_out == 1'b0));

  // R2
  early_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (ws_chg && !late_msb) |=> (ser_out == $past(ld_msb)));

  // R3
  delay_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (ws_chg && late_msb) |=> (ser_out == 1'b0));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && fr_gate && !fr_s && !ws_chg) |=> $stable(ser_out));

  // R10
  edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_out) |-> $past(fall));
endmodule

bind audtx_serializer audtx_serializer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .fall     (fall),
  .ws_chg   (ws_chg),
  .late_msb (late_msb),
  .fr_gate  (fr_gate),
  .fr_s     (sync_v[2]),
  .ld_msb   (ld_word[DW-1]),
  .ser_out  (ser_out)
);

// File: tb/sim_audtx_serializer.sv
`timescale 1ns/1ps
module sim_audtx_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_mst = 1'b0, fmt_i2s = 1'b0;
  logic [19:0] left_word = '0, right_word = '0;
  logic        word_valid = 1'b0;
  logic        bit_clk = 1'b1, word_sel = 1'b0, frame_en = 1'b1;
  logic        ser_out;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  audtx_serializer u0 (
    .clk(clk), .rst(rst), .fmt_mst(fmt_mst), .fmt_i2s(fmt_i2s),
    .left_word(left_word), .right_word(right_word), .word_valid(word_valid),
    .bit_clk(bit_clk), .word_sel(word_sel), .frame_en(frame_en), .ser_out(ser_out)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected 64-slot frame, bit i = slot i, from the requirements.
  function automatic logic [63:0] model(input logic [1:0] fmt, input logic [19:0] wl,
                                        input logic [19:0] wr, input logic [63:0] fs);
    logic [63:0] r;
    logic        late, gate, o, wt;
    logic [19:0] w;
    int          idx;
    late = (fmt != 2'b00);
    gate = (fmt == 2'b00);
    o = 1'b0; r = '0; wt = 1'b0; idx = 20;
    for (int h = 0; h < 2; h++) begin
      w = (h == 0) ? wl : wr;
      for (int s = 0; s < 32; s++) begin
        if (s == 0) begin
          if (late) begin o = 1'b0; wt = 1'b1; end
          else begin o = w[19]; idx = 1; end
        end else if (wt) begin
          o = w[19]; idx = 1; wt = 1'b0;
        end else if (!gate || fs[h*32+s]) begin
          if (idx < 20) begin o = w[19-idx]; idx++; end
          else o = 1'b0;
        end
        r[h*32+s] = o;
      end
    end
    return r;
  endfunction

  task automatic do_slot(input logic ws, input logic fs, input logic stb,
                         input logic [19:0] nl, input logic [19:0] nr,
                         output logic bit_o, output logic stab);
    logic a;
    bit_clk = 1'b0; word_sel = ws; frame_en = fs;
    if (stb) begin left_word = nl; right_word = nr; word_valid = 1'b1; end
    @(negedge clk); word_valid = 1'b0;
    repeat (3) @(negedge clk); bit_clk = 1'b1;
    repeat (2) @(negedge clk); a = ser_out;
    repeat (2) @(negedge clk); bit_o = ser_out;
    stab = (a === ser_out);
  endtask

  task automatic load_pair(input logic [19:0] l, input logic [19:0] r);
    left_word = l; right_word = r; word_valid = 1'b1;
    @(negedge clk); word_valid = 1'b0;
  endtask

  // Reset, select format, load a pair, idle slots at the right-channel level.
  task automatic start(input logic [1:0] fmt, input logic [19:0] l, input logic [19:0] r, input string req);
    logic b, st;
    logic [63:0] got;
    rst = 1'b1; {fmt_i2s, fmt_mst} = fmt; bit_clk = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    load_pair(l, r);
    got = '0;
    for (int i = 0; i < 6; i++) begin
      do_slot(fmt[1], 1'b1, 1'b0, '0, '0, b, st);
      got[i] = b;
    end
    check(got == '0, {req, " R1 idle before first word-select change"}, got, 64'h0);
  endtask

  task automatic run_frame(input string req, input logic [1:0] fmt, input logic [19:0] el,
                           input logic [19:0] er, input logic [63:0] fs, input int stb_slot,
                           input logic [19:0] nl, input logic [19:0] nr);
    logic [63:0] got, exp;
    logic b, st, all_st;
    logic lv;
    lv = ~fmt[1];
    all_st = 1'b1; got = '0;
    for (int s = 0; s < 64; s++) begin
      do_slot((s < 32) ? lv : ~lv, fs[s], (s == stb_slot), nl, nr, b, st);
      got[s] = b;
      all_st = all_st & st;
    end
    exp = model(fmt, el, er, fs);
    check(got == exp, req, got, exp);
    check(all_st, "R10 data stable within slot", {63'h0, all_st}, 64'h1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(ser_out == 1'b0, "R1 reset value", {63'h0, ser_out}, 64'h0);
  endtask

  task automatic t_msbj();
    start(2'b00, 20'hA5C3F, 20'h80001, "msbj");
    run_frame("R2 R5 R6 msbj frame", 2'b00, 20'hA5C3F, 20'h80001, '1, -1, '0, '0);
    run_frame("R9 msbj repeat of pair", 2'b00, 20'hA5C3F, 20'h80001, '1, -1, '0, '0);
  endtask

  task automatic t_gate();
    start(2'b00, 20'h7F0E1, 20'hC3A55, "gate");
    run_frame("R7 frame_en gating", 2'b00, 20'h7F0E1, 20'hC3A55, 64'hF0FF_F3FF_FFF0_C3FE, -1, '0, '0);
    run_frame("R7 gating truncation", 2'b00, 20'h7F0E1, 20'hC3A55, 64'h0000_0FF1_0000_7FFF, -1, '0, '0);
  endtask

  task automatic t_i2s_slave();
    start(2'b10, 20'h12345, 20'hFEDCB, "sl_i2s");
    run_frame("R3 R8 slave i2s frame_en low", 2'b10, 20'h12345, 20'hFEDCB, 64'h0, -1, '0, '0);
    run_frame("R8 slave i2s frame_en pattern", 2'b10, 20'h12345, 20'hFEDCB, 64'hF0F0_3C3C_0FF0_A5A5, -1, '0, '0);
  endtask

  task automatic t_mst_i2s();
    start(2'b11, 20'h80000, 20'h7FFFF, "m_i2s");
    run_frame("R3 R5 master i2s extremes", 2'b11, 20'h80000, 20'h7FFFF, 64'h5555_5555_5555_5555, -1, '0, '0);
  endtask

  task automatic t_mst_like();
    start(2'b01, 20'h9B6D3, 20'h0F00F, "m_like");
    run_frame("R4 R8 master like frame", 2'b01, 20'h9B6D3, 20'h0F00F, 64'h00FF_00FF_1234_0000, -1, '0, '0);
  endtask

  task automatic t_latch();
    start(2'b00, 20'h11111, 20'h22222, "latch");
    run_frame("R9 strobe in left half keeps pair", 2'b00, 20'h11111, 20'h22222, '1, 10, 20'hABCDE, 20'h54321);
    run_frame("R9 new pair next frame", 2'b00, 20'hABCDE, 20'h54321, '1, -1, '0, '0);
    run_frame("R9 strobe in right half keeps right", 2'b00, 20'hABCDE, 20'h54321, '1, 40, 20'h0C0C0, 20'hF0F0F);
    run_frame("R9 right-half pair next frame", 2'b00, 20'h0C0C0, 20'hF0F0F, '1, -1, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_msbj();
    t_gate();
    t_i2s_slave();
    t_mst_i2s();
    t_mst_like();
    t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule